// File: doc/BRIEF.md
# Clock Policy Engine Controller

This block is a small register-mapped controller for a four-level clock policy engine. Software reaches it through a plain word-addressed read/write bus. Policy 0 is the lowest-power operating point and policy 3 the highest. Each policy has its own clock-enable mask. The controller drives the number of the policy in force and the enable vector taken from that policy's mask. All protected registers are behind a password lock. The lock is opened and closed by writing a keyed word to address 0.

A policy change starts when the go bit is written into the control word. The change can be synchronous, where the new policy takes effect at once and go stays busy while the supply settles. It can also be asynchronous, where a settling delay (a programmable counter standing in for a voltage ramp) runs first and the requested policy is copied into the active one when go clears. A separate stop word halts the engine. The clock masks can only be rewritten while the engine is stopped. The next go restarts it.

Top module: `clkpol_ctrl`

## Requirements
- R1: After reset the active policy is 2, all masks are all ones, the block is locked, and neither go nor stop is busy. So clk_en is all ones, and word 0 and the busy bits read 0.
- R2: A write to word 0 whose bits 31:8 equal 0x00A5A5 sets the lock state to bit 0 (1 = unlocked). A write to word 0 with any other upper value changes nothing. Word 0 reads back the unlocked flag in bit 0.
- R3: While locked, writes to the control word (1), the stop word (2) and the mask words (4 to 7) have no effect.
- R4: A control write with bit 0 (go) set, made while unlocked and idle, latches the requested policy from bits 9:8. Control bit 0 then reads 1 for exactly BUSY_CYC cycles and clears by itself. Control reads return the requested policy in bits 9:8 and the active policy in bits 13:12. A go written while the engine is busy is ignored.
- R5: If control bit 1 (synchronous) is set with go, the active policy becomes the requested one in the same cycle that busy starts.
- R6: If bit 1 is clear and bit 2 (auto-copy) is set, the active policy holds its old value while busy. It takes the requested value in the cycle that busy clears. If both bits are clear, the active policy does not change.
- R7: Writing 1 to stop-word bit 0 while unlocked, idle and not stopped sets stop bit 0 for exactly BUSY_CYC cycles. After that, stop bit 1 (stopped) reads 1. A stop written while go is busy is ignored.
- R8: Mask word 4+p holds the enable mask of policy p, with bit i controlling clock i in all four words. Mask words accept writes only while unlocked and stopped. A later go clears the stopped flag.
- R9: clk_en equals the mask of the active policy, one cycle after either of them changes. Read data is registered and appears one cycle after the address.
- R10: The control word is written as a whole word. A write without go has no effect, and the mode bits of an earlier write are not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| active_pol | output | 2 | Policy currently in force |
| clk_en | output | NCLK | Clock enables of the active policy |

## Verification
A write is captured at the clock edge where bus_we is high. Any state it changes is visible through a read addressed right after that edge, which returns data one edge later. The bench therefore reads the control or stop word once per cycle straight after a go or stop write. It requires exactly BUSY_CYC consecutive busy reads. The active policy is checked on the first busy read (synchronous) and on the first idle read (auto-copy). clk_en lags the active policy and mask by one register, so the bench waits two cycles before comparing it with the mask computed in the bench. The bench sweeps every policy under each of the three modes and writes, then reads back, all four masks.

// File: rtl/clkpol_pkg.sv
package clkpol_pkg;
  localparam int          POLICIES   = 4;
  localparam logic [1:0]  POL_RESET  = 2'd2;
  localparam logic [23:0] ACCESS_KEY = 24'h00A5A5;
  localparam int WORD_ACCESS = 0;
  localparam int WORD_CTRL   = 1;
  localparam int WORD_STOP   = 2;
  localparam int CTL_GO   = 0;
  localparam int CTL_SYNC = 1;
  localparam int CTL_COPY = 2;
  localparam int CTL_TGT  = 8;
  localparam int CTL_ACT  = 12;
  typedef logic [1:0] pol_t;
endpackage

// File: rtl/clkpol_lock.sv
module clkpol_lock
  import clkpol_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_we,
  input  logic [23:0] key,
  input  logic        open_bit,
  output logic        unlocked
);
  always_ff @(posedge clk) begin
    if (rst)                         unlocked <= 1'b0;
    else if (acc_we && key == ACCESS_KEY) unlocked <= open_bit;
  end

  AST_LOCK_ONLY_BY_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !acc_we |=> $stable(unlocked)); // R2
endmodule

// File: rtl/clkpol_seq.sv
module clkpol_seq
  import clkpol_pkg::*;
#(
  parameter int BUSY_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic go_wr,
  input  logic stop_wr,
  input  logic sync_req,
  input  logic copy_req,
  input  pol_t tgt_in,
  output logic busy,
  output logic stopping,
  output logic stopped,
  output pol_t active,
  output pol_t target
);
  localparam int CW = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(BUSY_CYC - 1);

  logic [CW-1:0] cnt;
  logic          sync_q, copy_q;
  logic          running;

  assign running = busy | stopping;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      stopping <= 1'b0;
      stopped  <= 1'b0;
      active   <= POL_RESET;
      target   <= POL_RESET;
      sync_q   <= 1'b0;
      copy_q   <= 1'b0;
      cnt      <= '0;
    end else if (running) begin
      if (cnt == '0) begin
        busy     <= 1'b0;
        stopping <= 1'b0;
        if (stopping) stopped <= 1'b1;
        if (busy && !sync_q && copy_q) active <= target;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (go_wr) begin
      busy    <= 1'b1;
      stopped <= 1'b0;
      target  <= tgt_in;
      sync_q  <= sync_req;
      copy_q  <= copy_req;
      cnt     <= CNT_LOAD;
      if (sync_req) active <= tgt_in;
    end else if (stop_wr && !stopped) begin
      stopping <= 1'b1;
      cnt      <= CNT_LOAD;
    end
  end

  AST_GO_SELF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == '0) |=> !busy); // R4
  AST_ACTIVE_HELD_IN_RAMP: assert property (@(posedge clk) disable iff (rst)
    (running && cnt != '0) |=> $stable(active)); // R6
  AST_ONE_OPERATION: assert property (@(posedge clk) disable iff (rst)
    !(busy && stopping)); // R7
endmodule

// File: rtl/clkpol_masks.sv
module clkpol_masks
  import clkpol_pkg::*;
#(
  parameter int NCLK = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_req,
  input  logic            unlocked,
  input  logic            stopped,
  input  logic [1:0]      widx,
  input  logic [NCLK-1:0] wdata,
  input  logic [1:0]      ridx,
  input  pol_t            sel,
  output logic [NCLK-1:0] rd_mask,
  output logic [NCLK-1:0] sel_mask
);
  logic [NCLK-1:0]          mem [POLICIES];
  logic [POLICIES*NCLK-1:0] flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < POLICIES; i++) mem[i] <= '1;
    end else if (wr_req && unlocked && stopped) begin
      mem[widx] <= wdata;
    end
  end

  always_comb begin
    for (int i = 0; i < POLICIES; i++) flat[i*NCLK +: NCLK] = mem[i];
  end

  assign rd_mask  = mem[ridx];
  assign sel_mask = mem[sel];

  AST_MASK_GUARDED: assert property (@(posedge clk) disable iff (rst)
    (!unlocked || !stopped) |=> $stable(flat)); // R8
endmodule

// File: rtl/clkpol_ctrl.sv
module clkpol_ctrl
  import clkpol_pkg::*;
#(
  parameter int NCLK     = 16,
  parameter int BUSY_CYC = 8,
  parameter int AW       = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [1:0]      active_pol,
  output logic [NCLK-1:0] clk_en
);
  logic unlocked, busy, stopping, stopped;
  logic acc_we, go_wr, stop_wr, mask_wr, is_mask;
  pol_t target;
  logic [NCLK-1:0] rd_mask, sel_mask;
  logic [31:0] rd_next;

  assign is_mask = (bus_addr[AW-1:2] == (AW-2)'(1));
  assign acc_we  = bus_we && bus_addr == AW'(WORD_ACCESS);
  assign go_wr   = bus_we && unlocked && bus_addr == AW'(WORD_CTRL) && bus_wdata[CTL_GO];
  assign stop_wr = bus_we && unlocked && bus_addr == AW'(WORD_STOP) && bus_wdata[0];
  assign mask_wr = bus_we && is_mask;

  clkpol_lock u_lock (
    .clk(clk), .rst(rst), .acc_we(acc_we),
    .key(bus_wdata[31:8]), .open_bit(bus_wdata[0]), .unlocked(unlocked)
  );

  clkpol_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
    .clk(clk), .rst(rst), .go_wr(go_wr), .stop_wr(stop_wr),
    .sync_req(bus_wdata[CTL_SYNC]), .copy_req(bus_wdata[CTL_COPY]),
    .tgt_in(bus_wdata[CTL_TGT +: 2]), .busy(busy), .stopping(stopping),
    .stopped(stopped), .active(active_pol), .target(target)
  );

  clkpol_masks #(.NCLK(NCLK)) u_masks (
    .clk(clk), .rst(rst), .wr_req(mask_wr), .unlocked(unlocked),
    .stopped(stopped), .widx(bus_addr[1:0]), .wdata(bus_wdata[NCLK-1:0]),
    .ridx(bus_addr[1:0]), .sel(active_pol), .rd_mask(rd_mask),
    .sel_mask(sel_mask)
  );

  always_comb begin
    rd_next = '0;
    if (is_mask) begin
      rd_next[NCLK-1:0] = rd_mask;
    end else begin
      case (int'(bus_addr))
        WORD_ACCESS: rd_next[0] = unlocked;
        WORD_CTRL: begin
          rd_next[CTL_GO]       = busy;
          rd_next[CTL_TGT +: 2] = target;
          rd_next[CTL_ACT +: 2] = active_pol;
        end
        WORD_STOP: begin
          rd_next[0] = stopping;
          rd_next[1] = stopped;
        end
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      clk_en    <= '1;
    end else begin
      bus_rdata <= rd_next;
      clk_en    <= sel_mask;
    end
  end

  AST_LOCKED_NO_GO: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && !busy) |=> !busy); // R3
endmodule

// File: tb/clkpol_ctrl_test.sv
module clkpol_ctrl_test;
  localparam int NCLK = 16;
  localparam int BUSY = 8;
  localparam int AW   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0] active_pol;
  logic [NCLK-1:0] clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [1:0] exp_act;
  logic [31:0] v;

  always #5 clk = ~clk;

  clkpol_ctrl #(.NCLK(NCLK), .BUSY_CYC(BUSY), .AW(AW)) uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .active_pol(active_pol), .clk_en(clk_en)
  );

  function automatic logic [NCLK-1:0] pat(int p);
    return NCLK'(32'hA5C3 ^ (32'h1357 * (p + 1)));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = AW'(a);
    @(posedge clk);
    #1 d = bus_rdata;
    @(negedge clk);
  endtask

  // mode 0: go only, 1: auto-copy, 2: synchronous
  task automatic go_op(int mode, logic [1:0] tgt);
    logic [1:0] old;
    int n;
    bit idle;
    logic [31:0] r;
    old = exp_act;
    wr(1, 32'h1 | (mode == 2 ? 32'h2 : 32'h0) | (mode == 1 ? 32'h4 : 32'h0) | (32'(tgt) << 8));
    n = 0; idle = 1'b0;
    for (int i = 0; i < BUSY + 4 && !idle; i++) begin
      rd(1, r);
      if (r[0]) begin
        n++;
        if (mode == 2 && n == 1) chk(r[13:12] == tgt, "R5 sync active", r[13:12], tgt);
        if (mode == 1 && n == 1) chk(r[13:12] == old, "R6 active held", r[13:12], old);
        if (n == 1) chk(r[9:8] == tgt, "R4 target field", r[9:8], tgt);
      end else begin
        idle = 1'b1;
        if (mode == 1) chk(r[13:12] == tgt, "R6 copied at clear", r[13:12], tgt);
        if (mode == 0) chk(r[13:12] == old, "R6 no copy", r[13:12], old);
      end
    end
    chk(n == BUSY, "R4 busy length", n, BUSY);
    if (mode != 0) exp_act = tgt;
    @(negedge clk); @(negedge clk);
    chk(active_pol == exp_act, "R9 active port", active_pol, exp_act);
    chk(clk_en == pat(exp_act), "R9 clk_en", clk_en, pat(exp_act));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_act = 2'd2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(active_pol == 2'd2, "R1 reset policy", active_pol, 2);
    chk(clk_en == '1, "R1 reset clk_en", clk_en, 16'hFFFF);
    rd(0, v); chk(v == 0, "R1 locked", v, 0);
    rd(1, v); chk(v == 32'h2200, "R1 ctrl idle", v, 32'h2200);
    rd(2, v); chk(v == 0, "R1 stop idle", v, 0);
    rd(4, v); chk(v == 32'hFFFF, "R1 mask reset", v, 32'hFFFF);
    // R3 locked writes ignored
    wr(2, 32'h1); rd(2, v); chk(v == 0, "R3 stop while locked", v, 0);
    wr(1, 32'h301); rd(1, v); chk(v[0] == 1'b0, "R3 go while locked", v[0], 0);
    // R2 wrong key
    wr(0, 32'h12345601); rd(0, v); chk(v == 0, "R2 bad key", v, 0);
    wr(0, 32'h00A5A501); rd(0, v); chk(v == 1, "R2 unlock", v, 1);
    // R8 mask write while running
    wr(4, 32'h0); rd(4, v); chk(v == 32'hFFFF, "R8 mask running", v, 32'hFFFF);
    // R10 control write without go
    wr(1, 32'h306); rd(1, v); chk(v == 32'h2200, "R10 no go", v, 32'h2200);
    // R7 stop
    begin
      int n;
      n = 0;
      wr(2, 32'h1);
      for (int i = 0; i < BUSY + 4; i++) begin
        rd(2, v);
        if (v[0]) n++;
      end
      chk(n == BUSY, "R7 stop length", n, BUSY);
      chk(v == 32'h2, "R7 stopped flag", v, 2);
    end
    // R8 masks
    for (int p = 0; p < 4; p++) wr(4 + p, 32'(pat(p)));
    for (int p = 0; p < 4; p++) begin
      rd(4 + p, v); chk(v == 32'(pat(p)), "R8 mask readback", v, pat(p));
    end
    @(negedge clk);
    chk(clk_en == pat(2), "R9 clk_en after mask", clk_en, pat(2));
    // R3 locked mask write
    wr(0, 32'h00A5A500); wr(4, 32'h0);
    rd(4, v); chk(v == 32'(pat(0)), "R3 mask while locked", v, pat(0));
    wr(0, 32'h00A5A501);
    // sweep
    for (int p = 0; p < 4; p++) begin
      go_op(0, 2'(p));
      go_op(1, 2'(p));
      go_op(2, 2'((p + 2) % 4));
    end
    rd(2, v); chk(v == 0, "R8 go clears stopped", v, 0);
    // R4 go while busy, R7 stop while busy
    begin
      logic [1:0] t;
      t = 2'(exp_act + 1);
      wr(1, 32'h5 | (32'(t) << 8));
      wr(1, 32'h3 | (32'(2'(t + 1)) << 8));
      wr(2, 32'h1);
      repeat (BUSY + 2) @(negedge clk);
      chk(active_pol == t, "R4 go while busy ignored", active_pol, t);
      rd(2, v); chk(v == 0, "R7 stop while busy ignored", v, 0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule